// File: doc/BRIEF.md
# On-Screen-Display Window Compositor

This block decides, for every dot of an on-screen-display character grid, which background layer lies behind the character. Up to four rectangular windows are programmed in character-cell units. Each window has its own enable, fill colour, and drop shadow, and the shadow has its own colour, width and height. The windows are stacked in a fixed priority order. The block merges that stack with the per-character foreground dot, foreground colour and background colour. The result is one registered 3-bit RGB value and two flags that report whether the dot falls on a window body or on a window shadow.

The display pipeline drives four things each dot clock: the current character row and column, the dot index across the cell, and the scan-line index down the cell. One cycle later the pipeline takes the colour and the flags. The configuration is a flat bank of 30-bit words, one word per window, with window 0 in the lowest bits. Each word is laid out as follows:

| Bits | Field |
|------|-------|
| [3:0] | first row |
| [7:4] | last row |
| [12:8] | first column |
| [17:13] | last column |
| [18] | enable |
| [19] | shadow enable |
| [22:20] | fill colour |
| [24:23] | shadow width code |
| [26:25] | shadow height code |
| [29:27] | shadow colour |

Colours are {R,G,B}.

Top module: `osd_win_compositor`

## Requirements
- R1: An enabled window covers every cell whose row and column both lie within its bounds. Both bounds are inclusive. On a covered dot, win_hit_o is 1 and the window fill colour is shown when no character layer is drawn.
- R2: A window whose first row is greater than its last row, or whose first column is greater than its last column, covers no cell and casts no shadow.
- R3: Where window bodies overlap, the lowest-numbered window wins. Window 0 has the highest priority.
- R4: A character foreground dot (fg_on_i=1) shows fg_rgb_i. Otherwise a non-zero bg_rgb_i is shown as itself. Only bg_rgb_i=000 lets the window or shadow colour through. With no layer at all, the output is 000.
- R5: Shadow width code 00/01/10/11 gives 2/4/6/8 dots. In the column just after the last column, dots with index below the width are shadow. On a shadow dot, shd_hit_o is 1 and the shadow colour is shown.
- R6: Shadow height code 00/01/10/11 gives 2/4/6/8 scan lines. In the row just after the last row, lines with index below the height are shadow.
- R7: The shadow is the window rectangle moved right by the width and down by the height, minus the body. The first width dots of the first column and the first height lines of the first row are not shadow.
- R8: A shadow is drawn only when the window is enabled and its shadow enable bit is 1. A higher-priority body hides a lower window's shadow. A shadow hides a lower-priority window's body.
- R9: A disabled window casts no fill and no shadow. Any character whose cell lies inside its area is suppressed: neither its foreground nor its background is shown.
- R10: The outputs change one clock after the inputs. While rst_ni is low, the outputs are 000, 0 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_cfg_i | input | N_WIN*30 | Window configuration words, window 0 lowest |
| row_i | input | 4 | Character row of the current dot |
| col_i | input | 5 | Character column of the current dot |
| dot_i | input | DOT_W | Dot index across the cell |
| line_i | input | LINE_W | Scan-line index down the cell |
| fg_on_i | input | 1 | Font dot is lit |
| fg_rgb_i | input | 3 | Character foreground colour |
| bg_rgb_i | input | 3 | Character background colour, 000 means transparent |
| rgb_o | output | 3 | Composited colour |
| win_hit_o | output | 1 | Dot lies on the winning window body |
| shd_hit_o | output | 1 | Dot lies on the winning window shadow |

## Verification
The block has only one pipeline register, so any wrong hit, offset or priority decision shows at the ports on the very next clock. It appears as a wrong colour or a wrong flag for exactly the dot that provoked it. The checks therefore aim at the points where decisions flip. These are the last inclusive column and row, the dot and line equal to the shadow size, the offset corner at the first column and first row, and overlaps between bodies and shadows of neighbouring priorities. An inverted compare or an off-by-one span shows up as a single misplaced pixel at one of these probes.

// File: rtl/osd_win_pkg.sv
package osd_win_pkg;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 5;
  localparam int RGB_W  = 3;
  localparam int CODE_W = 2;
  localparam int SPAN_W = 4;

  typedef logic [RGB_W-1:0] rgb_t;

  typedef struct packed {
    rgb_t              scol;
    logic [CODE_W-1:0] shc;
    logic [CODE_W-1:0] swc;
    rgb_t              fill;
    logic              shd_en;
    logic              en;
    logic [COL_W-1:0]  ce;
    logic [COL_W-1:0]  cs;
    logic [ROW_W-1:0]  re;
    logic [ROW_W-1:0]  rs;
  } win_cfg_t;

  localparam int CFG_W = $bits(win_cfg_t);

  // code 0..3 -> 2,4,6,8
  function automatic logic [SPAN_W-1:0] shd_span(input logic [CODE_W-1:0] code);
    return {1'b0, code, 1'b0} + SPAN_W'(2);
  endfunction
endpackage

// File: rtl/osd_win_hit.sv
module osd_win_hit
  import osd_win_pkg::*;
#(
  parameter int DOT_W  = 4,
  parameter int LINE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  win_cfg_t          cfg_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              area_o,
  output logic              body_o,
  output logic              shd_o
);
  logic [DOT_W-1:0]  sw_span;
  logic [LINE_W-1:0] sh_span;
  logic [ROW_W:0]    re_p1;
  logic [COL_W:0]    ce_p1;
  logic              row_in, col_in, bounds_ok;
  logic              sx_lo, sx_hi, sy_lo, sy_hi;

  assign sw_span = DOT_W'(shd_span(cfg_i.swc));
  assign sh_span = LINE_W'(shd_span(cfg_i.shc));
  assign re_p1   = {1'b0, cfg_i.re} + 1'b1;
  assign ce_p1   = {1'b0, cfg_i.ce} + 1'b1;

  assign bounds_ok = (cfg_i.rs <= cfg_i.re) && (cfg_i.cs <= cfg_i.ce);
  assign row_in    = (row_i >= cfg_i.rs) && (row_i <= cfg_i.re);
  assign col_in    = (col_i >= cfg_i.cs) && (col_i <= cfg_i.ce);
  assign area_o    = row_in && col_in;
  assign body_o    = cfg_i.en && area_o;

  // moved rectangle: shifted right by sw dots and down by sh lines
  assign sx_lo = (col_i > cfg_i.cs) || ((col_i == cfg_i.cs) && (dot_i >= sw_span));
  assign sx_hi = (col_i <= cfg_i.ce) || (({1'b0, col_i} == ce_p1) && (dot_i < sw_span));
  assign sy_lo = (row_i > cfg_i.rs) || ((row_i == cfg_i.rs) && (line_i >= sh_span));
  assign sy_hi = (row_i <= cfg_i.re) || (({1'b0, row_i} == re_p1) && (line_i < sh_span));

  assign shd_o = cfg_i.en && cfg_i.shd_en && bounds_ok &&
                 sx_lo && sx_hi && sy_lo && sy_hi && !area_o;

  AST_DIS_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |-> (!body_o && !shd_o)); // R9
  AST_EMPTY_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.rs > cfg_i.re) |-> (!body_o && !shd_o)); // R2
  AST_SHD_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shd_o && (col_i > cfg_i.ce)) |-> (32'(dot_i) < 8)); // R5
  AST_SHD_HEIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shd_o && (row_i > cfg_i.re)) |-> (32'(line_i) < 8)); // R6
  AST_SHD_OFF_BODY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shd_o |-> !(row_in && col_in)); // R7
endmodule

// File: rtl/osd_win_prio.sv
module osd_win_prio
  import osd_win_pkg::*;
#(
  parameter int N_WIN = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_WIN-1:0]      body_i,
  input  logic [N_WIN-1:0]      shd_i,
  input  rgb_t [N_WIN-1:0]      fill_i,
  input  rgb_t [N_WIN-1:0]      scol_i,
  output logic                  sel_body_o,
  output logic                  sel_shd_o,
  output rgb_t                  sel_rgb_o
);
  // walk lowest priority first so the lowest index overwrites
  always_comb begin
    sel_body_o = 1'b0;
    sel_shd_o  = 1'b0;
    sel_rgb_o  = '0;
    for (int i = N_WIN - 1; i >= 0; i--) begin
      if (body_i[i]) begin
        sel_body_o = 1'b1;
        sel_shd_o  = 1'b0;
        sel_rgb_o  = fill_i[i];
      end else if (shd_i[i]) begin
        sel_body_o = 1'b0;
        sel_shd_o  = 1'b1;
        sel_rgb_o  = scol_i[i];
      end
    end
  end

  AST_TOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    body_i[0] |-> (sel_body_o && (sel_rgb_o == fill_i[0]))); // R3
  AST_ONE_LAYER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_body_o && sel_shd_o)); // R8
  AST_NO_PHANTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((body_i == '0) && (shd_i == '0)) |-> (!sel_body_o && !sel_shd_o)); // R1
endmodule

// File: rtl/osd_win_compositor.sv
module osd_win_compositor
  import osd_win_pkg::*;
#(
  parameter int N_WIN  = 4,
  parameter int DOT_W  = 4,
  parameter int LINE_W = 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_WIN*CFG_W-1:0] win_cfg_i,
  input  logic [ROW_W-1:0]       row_i,
  input  logic [COL_W-1:0]       col_i,
  input  logic [DOT_W-1:0]       dot_i,
  input  logic [LINE_W-1:0]      line_i,
  input  logic                   fg_on_i,
  input  logic [RGB_W-1:0]       fg_rgb_i,
  input  logic [RGB_W-1:0]       bg_rgb_i,
  output logic [RGB_W-1:0]       rgb_o,
  output logic                   win_hit_o,
  output logic                   shd_hit_o
);
  logic [N_WIN-1:0] area, body, shd, supp_vec;
  rgb_t [N_WIN-1:0] fill, scol;
  logic             sel_body, sel_shd, suppress;
  rgb_t             sel_rgb, rgb_d;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    win_cfg_t cfg;
    assign cfg = win_cfg_t'(win_cfg_i[g*CFG_W +: CFG_W]);

    osd_win_hit #(
      .DOT_W  (DOT_W),
      .LINE_W (LINE_W)
    ) u_hit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (cfg),
      .row_i  (row_i),
      .col_i  (col_i),
      .dot_i  (dot_i),
      .line_i (line_i),
      .area_o (area[g]),
      .body_o (body[g]),
      .shd_o  (shd[g])
    );

    assign fill[g]     = cfg.fill;
    assign scol[g]     = cfg.scol;
    assign supp_vec[g] = area[g] && !cfg.en;
  end

  osd_win_prio #(
    .N_WIN (N_WIN)
  ) u_prio (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .body_i     (body),
    .shd_i      (shd),
    .fill_i     (fill),
    .scol_i     (scol),
    .sel_body_o (sel_body),
    .sel_shd_o  (sel_shd),
    .sel_rgb_o  (sel_rgb)
  );

  assign suppress = |supp_vec;

  always_comb begin
    if (!suppress && fg_on_i)                rgb_d = fg_rgb_i;
    else if (!suppress && bg_rgb_i != '0)    rgb_d = bg_rgb_i;
    else                                     rgb_d = sel_rgb;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_o     <= '0;
      win_hit_o <= 1'b0;
      shd_hit_o <= 1'b0;
    end else begin
      rgb_o     <= rgb_d;
      win_hit_o <= sel_body;
      shd_hit_o <= sel_shd;
    end
  end

  AST_FG_SHOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fg_on_i && !suppress) |=> (rgb_o == $past(fg_rgb_i))); // R4
  AST_BG_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fg_on_i && (bg_rgb_i != '0) && !suppress) |=> (rgb_o == $past(bg_rgb_i))); // R4
  AST_SUPP_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suppress && !sel_body && !sel_shd) |=> (rgb_o == '0)); // R9
  AST_FLAG_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    body[0] |=> win_hit_o); // R10
endmodule

// File: tb/osd_win_compositor_tb.sv
`timescale 1ns/1ps
module osd_win_compositor_tb;
  import osd_win_pkg::*;

  localparam int N_WIN  = 4;
  localparam int DOT_W  = 4;
  localparam int LINE_W = 7;
  localparam int NV     = 22;

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic [N_WIN*CFG_W-1:0] win_cfg_i;
  logic [ROW_W-1:0]       row_i;
  logic [COL_W-1:0]       col_i;
  logic [DOT_W-1:0]       dot_i;
  logic [LINE_W-1:0]      line_i;
  logic                   fg_on_i;
  logic [2:0]             fg_rgb_i, bg_rgb_i;
  logic [2:0]             rgb_o;
  logic                   win_hit_o, shd_hit_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  osd_win_compositor #(.N_WIN(N_WIN), .DOT_W(DOT_W), .LINE_W(LINE_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_cfg_i(win_cfg_i),
    .row_i(row_i), .col_i(col_i), .dot_i(dot_i), .line_i(line_i),
    .fg_on_i(fg_on_i), .fg_rgb_i(fg_rgb_i), .bg_rgb_i(bg_rgb_i),
    .rgb_o(rgb_o), .win_hit_o(win_hit_o), .shd_hit_o(shd_hit_o)
  );

  function automatic logic [29:0] mk_cfg(int rs, int re, int cs, int ce, int en, int se,
                                         int fill, int swc, int shc, int scol);
    return {3'(scol), 2'(shc), 2'(swc), 3'(fill), 1'(se), 1'(en),
            5'(ce), 5'(cs), 4'(re), 4'(rs)};
  endfunction

  // req,row,col,dot,line,fg_on,fg,bg -> rgb,win,shd
  function automatic logic [35:0] vv(int req, int row, int col, int dot, int line, int fon,
                                     int fg, int bg, int er, int ew, int es);
    return {4'(req), 4'(row), 5'(col), 4'(dot), 7'(line), 1'(fon), 3'(fg), 3'(bg),
            3'(er), 1'(ew), 1'(es)};
  endfunction

  localparam logic [35:0] VEC [NV] = '{
    vv(1,  2,  3,  0,  0, 0, 0, 0, 1, 1, 0),  // R1 first corner
    vv(1,  4,  6, 11, 17, 0, 0, 0, 1, 1, 0),  // R1 last corner inclusive
    vv(1,  1,  3,  5,  5, 0, 0, 0, 0, 0, 0),  // R1 above window
    vv(3,  4,  5,  0,  0, 0, 0, 0, 1, 1, 0),  // R3 overlap, window 0 wins
    vv(3,  5,  5,  0,  5, 0, 0, 0, 4, 1, 0),  // R3 window 1 alone
    vv(5,  2,  7,  3,  5, 0, 0, 0, 2, 0, 1),  // R5 right band inside 4 dots
    vv(5,  2,  7,  4,  5, 0, 0, 0, 0, 0, 0),  // R5 dot equals width
    vv(7,  2,  7,  3,  1, 0, 0, 0, 0, 0, 0),  // R7 top offset lines
    vv(7,  5,  3,  1,  0, 0, 0, 0, 0, 0, 0),  // R7 left offset dots
    vv(6,  5,  3,  4,  1, 0, 0, 0, 2, 0, 1),  // R6 bottom band
    vv(6,  5,  4,  0,  2, 0, 0, 0, 0, 0, 0),  // R6 line equals height
    vv(6,  9, 13,  7,  7, 0, 0, 0, 3, 0, 1),  // R6 8-line corner
    vv(5,  9, 13,  8,  0, 0, 0, 0, 0, 0, 0),  // R5 8-dot limit
    vv(5,  6, 13,  7,  0, 0, 0, 0, 3, 0, 1),  // R5 8-dot band
    vv(8,  4,  7,  2,  0, 0, 0, 0, 2, 0, 1),  // R8 shadow over lower body
    vv(4,  2,  3,  0,  0, 1, 5, 0, 5, 1, 0),  // R4 foreground dot
    vv(4,  2,  3,  0,  0, 0, 0, 3, 3, 1, 0),  // R4 own background
    vv(4,  0,  0,  0,  0, 1, 6, 0, 6, 0, 0),  // R4 no window
    vv(9, 11,  2,  0,  0, 1, 7, 2, 0, 0, 0),  // R9 character suppressed
    vv(9, 11,  5,  0,  0, 0, 0, 0, 0, 0, 0),  // R9 no shadow
    vv(2,  7, 22,  0,  0, 0, 0, 0, 0, 0, 0),  // R2 reversed rows
    vv(2,  6, 26,  0,  0, 0, 0, 0, 0, 0, 0)   // R2 no shadow either
  };

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual rgb=%b win=%b shd=%b expected rgb=%b win=%b shd=%b",
               req, act[4:2], act[1], act[0], exp[4:2], exp[1], exp[0]);
    end
  endtask

  task automatic drive(input int row, input int col, input int dot, input int line,
                       input int fon, input int fg, input int bg);
    row_i = 4'(row); col_i = 5'(col); dot_i = 4'(dot); line_i = 7'(line);
    fg_on_i = 1'(fon); fg_rgb_i = 3'(fg); bg_rgb_i = 3'(bg);
  endtask

  task automatic step_check(input string req, input logic [4:0] exp);
    @(posedge clk_i); #1;
    check(req, {rgb_o, win_hit_o, shd_hit_o}, exp);
  endtask

  logic [29:0] c0, c1, c2, c3;

  initial begin
    c0 = mk_cfg(2, 4, 3, 6, 1, 1, 1, 1, 0, 2);
    c1 = mk_cfg(3, 8, 5, 12, 1, 1, 4, 3, 3, 3);
    c2 = mk_cfg(10, 12, 0, 4, 0, 1, 7, 0, 0, 5);
    c3 = mk_cfg(9, 5, 20, 25, 1, 1, 6, 1, 1, 1);
    win_cfg_i = {c3, c2, c1, c0};
    drive(2, 3, 0, 0, 1, 7, 0);
    repeat (3) @(posedge clk_i);
    #1 check("R10 reset", {rgb_o, win_hit_o, shd_hit_o}, 5'b000_0_0);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [35:0] v;
      v = VEC[k];
      @(negedge clk_i);
      drive(int'(v[31:28]), int'(v[27:23]), int'(v[22:19]), int'(v[18:12]),
            int'(v[11]), int'(v[10:8]), int'(v[7:5]));
      step_check($sformatf("R%0d vec%0d", v[35:32], k), v[4:0]);
    end

    // R8 shadow enable off
    @(negedge clk_i);
    c0 = mk_cfg(2, 4, 3, 6, 1, 0, 1, 1, 0, 2);
    win_cfg_i = {c3, c2, c1, c0};
    drive(2, 7, 3, 5, 0, 0, 0);
    step_check("R8 shadow disabled", 5'b000_0_0);

    // R8 higher body hides lower shadow
    @(negedge clk_i);
    c0 = mk_cfg(9, 9, 6, 6, 1, 0, 1, 1, 0, 2);
    win_cfg_i = {c3, c2, c1, c0};
    drive(9, 6, 0, 0, 0, 0, 0);
    step_check("R8 body over shadow", 5'b001_1_0);
    @(negedge clk_i);
    drive(9, 7, 0, 0, 0, 0, 0);
    step_check("R8 shadow beside body", 5'b011_0_1);

    // R10 one-cycle latency
    @(negedge clk_i);
    drive(0, 0, 0, 0, 1, 6, 0);
    step_check("R10 new value", 5'b110_0_0);
    @(negedge clk_i);
    drive(9, 6, 0, 0, 0, 0, 0);
    #1 check("R10 held before edge", {rgb_o, win_hit_o, shd_hit_o}, 5'b110_0_0);
    step_check("R10 after edge", 5'b001_1_0);

    // R10 asynchronous reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    #0.5 check("R10 async reset", {rgb_o, win_hit_o, shd_hit_o}, 5'b000_0_0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule